// File: doc/BRIEF.md
# Nested Interrupt Level and Vector Unit

This block chooses which pending interrupt the core should take next. It compares each maskable request's software-assigned two-bit priority with the core's current two-bit interrupt level. Reset, trap and the non-maskable request bypass that comparison. The block then presents the vector-table address and the level the core must load when it enters the handler. The level code is not monotonic in its binary value. From lowest to highest, the ranks are 10 (main program), 01 (level 1), 00 (level 2) and 11 (everything masked).

The block also sequences entry and return. When the core acknowledges entry, the take request is suppressed long enough for the core to load the new level. When the core strobes a return, the block pulses one of two actions. The action is either to restore the saved context or to drop straight back into low-power wait without touching the context. An activation-level input picks between the two. Stacking the context and fetching the vector word are left to the core.

Top module: `nil_vector_unit`

## Requirements
- R1: While and after synchronous reset, take_irq, ret_restore and ret_wait are 0, vec_addr is 0 and new_lvl is 00.
- R2: A maskable source n is eligible only when its request is high and the rank of its priority code is strictly greater than the rank of cur_lvl. The ranks are 10=0, 01=1, 00=2 and 11=3, and source n's code is user_prio[2n+1:2n].
- R3: A maskable source whose priority code is 10 is never taken.
- R4: With cur_lvl = 11, no maskable source is taken.
- R5: Reset, trap and NMI requests are taken whatever cur_lvl holds, in that order of precedence, ahead of every maskable source, and their new_lvl is 11.
- R6: Among eligible maskable sources, the one with the highest priority rank wins, and a tie goes to the lowest source number.
- R7: vec_addr = VEC_BASE + 4 × index (VEC_BASE defaults to 0x008000). The index is 0 for reset, 1 for trap, 2 for NMI and n+3 for maskable source n.
- R8: new_lvl equals the winning maskable source's priority code.
- R9: take_irq, vec_addr and new_lvl reflect the inputs sampled at the previous rising clock edge (one register stage).
- R10: When ent_ack is high at an edge, take_irq is 0 after that edge and after the next one, even if requests stay pending.
- R11: A ret_stb sampled high produces a one-cycle pulse on the next cycle. With act_lvl = 0 the pulse is on ret_restore, and with act_lvl = 1 it is on ret_wait. The two are never high together.
- R12: While take_irq is 0, vec_addr and new_lvl keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_req | input | 1 | Reset vector request |
| trap_req | input | 1 | Software trap request |
| nmi_req | input | 1 | Non-maskable request |
| user_req | input | N_USER | Maskable requests |
| user_prio | input | 2*N_USER | Two-bit priority code per maskable source |
| cur_lvl | input | 2 | Core's current level bits |
| act_lvl | input | 1 | Return action select: 0 restore, 1 back to wait |
| ent_ack | input | 1 | Core has entered the offered handler |
| ret_stb | input | 1 | Core executes an interrupt return |
| take_irq | output | 1 | Interrupt offered to the core |
| vec_addr | output | ADDR_W | Vector entry address of the winner |
| new_lvl | output | 2 | Level to load on entry |
| ret_restore | output | 1 | Return pulse: restore context |
| ret_wait | output | 1 | Return pulse: re-enter wait |

## Verification
The bench sweeps a four-source configuration through every priority assignment, every request pattern and every current level. This exposes a design that compares raw codes instead of ranks, which would let 10-coded sources through or block level-2 sources under level 1. It also exposes a design that breaks ties toward the higher source number, or offsets the user vector index wrongly. Directed cases put trap, NMI and reset under the full mask and in combination, which catches a precedence swap or a masked non-maskable. The entry blanking and both return actions are timed cycle by cycle, so a missing blank cycle or an inverted act_lvl shows up at once.

// File: rtl/nil_pkg.sv
package nil_pkg;
  typedef logic [1:0] lvl_t;

  localparam lvl_t LVL_MAIN = 2'b10;
  localparam lvl_t LVL_MASK = 2'b11;

  // ordering of the non-monotonic level code: main < L1 < L2 < masked
  function automatic logic [1:0] lvl_rank(input lvl_t code);
    case (code)
      2'b10:   lvl_rank = 2'd0;
      2'b01:   lvl_rank = 2'd1;
      2'b00:   lvl_rank = 2'd2;
      default: lvl_rank = 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/nil_rank.sv
module nil_rank
  import nil_pkg::*;
#(
  parameter int N_USER = 29
) (
  input  logic [N_USER-1:0]   user_req,
  input  logic [2*N_USER-1:0] user_prio,
  input  lvl_t                cur_lvl,
  output logic [N_USER-1:0]   user_ok,
  output logic [2*N_USER-1:0] user_rank
);
  logic [1:0] cur_rank;
  assign cur_rank = lvl_rank(cur_lvl);

  for (genvar g = 0; g < N_USER; g++) begin : g_src
    logic [1:0] r;
    assign r = lvl_rank(user_prio[2*g +: 2]);
    assign user_rank[2*g +: 2] = r;
    assign user_ok[g] = user_req[g] && (r > cur_rank);
  end
endmodule

// File: rtl/nil_pick.sv
module nil_pick
  import nil_pkg::*;
#(
  parameter int N_USER = 29,
  parameter int IDX_W  = $clog2(N_USER + 3)
) (
  input  logic                reset_req,
  input  logic                trap_req,
  input  logic                nmi_req,
  input  logic [N_USER-1:0]   user_ok,
  input  logic [2*N_USER-1:0] user_rank,
  input  logic [2*N_USER-1:0] user_prio,
  output logic                elig,
  output logic [IDX_W-1:0]    win_idx,
  output lvl_t                win_lvl
);
  localparam int FIRST_USER = 3;

  logic             u_found;
  logic [1:0]       u_best;
  logic [IDX_W-1:0] u_idx;
  lvl_t             u_lvl;

  // scan high-to-low with >= so the lowest number wins a rank tie
  always_comb begin
    u_found = 1'b0;
    u_best  = '0;
    u_idx   = '0;
    u_lvl   = LVL_MAIN;
    for (int i = N_USER - 1; i >= 0; i--) begin
      if (user_ok[i] && (!u_found || user_rank[2*i +: 2] >= u_best)) begin
        u_found = 1'b1;
        u_best  = user_rank[2*i +: 2];
        u_idx   = IDX_W'(i + FIRST_USER);
        u_lvl   = user_prio[2*i +: 2];
      end
    end
  end

  always_comb begin
    elig = reset_req | trap_req | nmi_req | u_found;
    if (reset_req) begin
      win_idx = IDX_W'(0);
      win_lvl = LVL_MASK;
    end else if (trap_req) begin
      win_idx = IDX_W'(1);
      win_lvl = LVL_MASK;
    end else if (nmi_req) begin
      win_idx = IDX_W'(2);
      win_lvl = LVL_MASK;
    end else begin
      win_idx = u_idx;
      win_lvl = u_lvl;
    end
  end
endmodule

// File: rtl/nil_seq.sv
module nil_seq
  import nil_pkg::*;
#(
  parameter int          IDX_W       = 5,
  parameter int          ADDR_W      = 24,
  parameter int          ENTRY_BYTES = 4,
  parameter [ADDR_W-1:0] VEC_BASE    = 24'h008000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              elig,
  input  logic [IDX_W-1:0]  win_idx,
  input  lvl_t              win_lvl,
  input  logic              ent_ack,
  input  logic              ret_stb,
  input  logic              act_lvl,
  output logic              take_irq,
  output logic [ADDR_W-1:0] vec_addr,
  output lvl_t              new_lvl,
  output logic              ret_restore,
  output logic              ret_wait
);
  logic blank_q;
  logic offer;

  assign offer = elig && !ent_ack && !blank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_q     <= 1'b0;
      take_irq    <= 1'b0;
      vec_addr    <= '0;
      new_lvl     <= 2'b00;
      ret_restore <= 1'b0;
      ret_wait    <= 1'b0;
    end else begin
      blank_q     <= ent_ack;
      take_irq    <= offer;
      if (offer) begin
        vec_addr <= VEC_BASE + ADDR_W'(win_idx) * ADDR_W'(ENTRY_BYTES);
        new_lvl  <= win_lvl;
      end
      ret_restore <= ret_stb && !act_lvl;
      ret_wait    <= ret_stb && act_lvl;
    end
  end

  // R10: entry acknowledge blanks the offer for two edges
  a_r10_blank_first: assert property (@(posedge clk) disable iff (rst)
    ent_ack |=> !take_irq);
  a_r10_blank_second: assert property (@(posedge clk) disable iff (rst)
    ent_ack |=> ##1 !take_irq);
  // R11: return actions
  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ret_restore && ret_wait));
  a_r11_restore: assert property (@(posedge clk) disable iff (rst)
    (ret_stb && !act_lvl) |=> ret_restore);
  a_r11_wait: assert property (@(posedge clk) disable iff (rst)
    (ret_stb && act_lvl) |=> ret_wait);
  // R9: an eligible unblocked request is offered on the next cycle
  a_r9_offer: assert property (@(posedge clk) disable iff (rst)
    (elig && !ent_ack && !blank_q) |=> take_irq);
  // R12: no offer leaves the vector and level untouched
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !offer |=> ($stable(vec_addr) && $stable(new_lvl)));
endmodule

// File: rtl/nil_vector_unit.sv
module nil_vector_unit
  import nil_pkg::*;
#(
  parameter int          N_USER      = 29,
  parameter int          ADDR_W      = 24,
  parameter int          ENTRY_BYTES = 4,
  parameter [ADDR_W-1:0] VEC_BASE    = 24'h008000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reset_req,
  input  logic                trap_req,
  input  logic                nmi_req,
  input  logic [N_USER-1:0]   user_req,
  input  logic [2*N_USER-1:0] user_prio,
  input  logic [1:0]          cur_lvl,
  input  logic                act_lvl,
  input  logic                ent_ack,
  input  logic                ret_stb,
  output logic                take_irq,
  output logic [ADDR_W-1:0]   vec_addr,
  output logic [1:0]          new_lvl,
  output logic                ret_restore,
  output logic                ret_wait
);
  localparam int IDX_W = $clog2(N_USER + 3);

  logic [N_USER-1:0]   user_ok;
  logic [2*N_USER-1:0] user_rank;
  logic                elig;
  logic [IDX_W-1:0]    win_idx;
  lvl_t                win_lvl;

  nil_rank #(.N_USER(N_USER)) u_rank (
    .user_req (user_req),
    .user_prio(user_prio),
    .cur_lvl  (cur_lvl),
    .user_ok  (user_ok),
    .user_rank(user_rank)
  );

  nil_pick #(.N_USER(N_USER), .IDX_W(IDX_W)) u_pick (
    .reset_req(reset_req),
    .trap_req (trap_req),
    .nmi_req  (nmi_req),
    .user_ok  (user_ok),
    .user_rank(user_rank),
    .user_prio(user_prio),
    .elig     (elig),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  nil_seq #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W),
    .ENTRY_BYTES(ENTRY_BYTES), .VEC_BASE(VEC_BASE)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .elig       (elig),
    .win_idx    (win_idx),
    .win_lvl    (win_lvl),
    .ent_ack    (ent_ack),
    .ret_stb    (ret_stb),
    .act_lvl    (act_lvl),
    .take_irq   (take_irq),
    .vec_addr   (vec_addr),
    .new_lvl    (new_lvl),
    .ret_restore(ret_restore),
    .ret_wait   (ret_wait)
  );

  // R4: under the full mask only reset, trap or NMI can produce an offer
  a_r4_full_mask: assert property (@(posedge clk) disable iff (rst)
    (cur_lvl == LVL_MASK && !reset_req && !trap_req && !nmi_req) |-> !elig);
  // R5: non-maskable sources always win with the masking level
  a_r5_nonmask: assert property (@(posedge clk) disable iff (rst)
    (reset_req || trap_req || nmi_req) |-> (elig && win_lvl == LVL_MASK && win_idx < IDX_W'(3)));
  // R3: a main-coded source is never the winner
  a_r3_main_code: assert property (@(posedge clk) disable iff (rst)
    (elig && win_idx >= IDX_W'(3)) |-> (win_lvl != LVL_MAIN));
endmodule

// File: tb/sim_nil_vector_unit.sv
`timescale 1ns/1ps
module sim_nil_vector_unit;
  localparam int NU = 4;
  localparam logic [23:0] BASE = 24'h008000;

  logic clk = 1'b0;
  logic rst;
  logic reset_req, trap_req, nmi_req, act_lvl, ent_ack, ret_stb;
  logic [NU-1:0]   user_req;
  logic [2*NU-1:0] user_prio;
  logic [1:0]      cur_lvl;
  logic            take_irq, ret_restore, ret_wait;
  logic [23:0]     vec_addr;
  logic [1:0]      new_lvl;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  nil_vector_unit #(.N_USER(NU)) u0 (
    .clk(clk), .rst(rst), .reset_req(reset_req), .trap_req(trap_req),
    .nmi_req(nmi_req), .user_req(user_req), .user_prio(user_prio),
    .cur_lvl(cur_lvl), .act_lvl(act_lvl), .ent_ack(ent_ack), .ret_stb(ret_stb),
    .take_irq(take_irq), .vec_addr(vec_addr), .new_lvl(new_lvl),
    .ret_restore(ret_restore), .ret_wait(ret_wait)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rnk(input logic [1:0] c);
    return (c == 2'b11) ? 3 : 2 - int'(c);
  endfunction

  initial begin
    #900000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [23:0] exp_vec;
    logic [1:0]  exp_lvl;
    rst = 1'b1; reset_req = 0; trap_req = 0; nmi_req = 0; act_lvl = 0;
    ent_ack = 0; ret_stb = 0; user_req = '0; user_prio = '0; cur_lvl = 2'b10;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 take", 32'(take_irq), 0);
    chk("R1 vec", 32'(vec_addr), 0);
    chk("R1 lvl", 32'(new_lvl), 0);
    chk("R1 ret", 32'({ret_restore, ret_wait}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle take", 32'(take_irq), 0);
    exp_vec = '0; exp_lvl = 2'b00;

    // R2 R3 R4 R6 R7 R8 R9 R12 sweep
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < 256; p++) begin
        for (int r = 0; r < 16; r++) begin
          int best_i, best_r;
          cur_lvl = 2'(c); user_prio = 8'(p); user_req = 4'(r);
          best_i = -1; best_r = -1;
          for (int i = 0; i < NU; i++) begin
            int ri;
            ri = rnk(user_prio[2*i +: 2]);
            if (user_req[i] && ri > rnk(cur_lvl) && ri > best_r) begin
              best_r = ri; best_i = i;
            end
          end
          if (best_i >= 0) begin
            exp_vec = BASE + 24'(4 * (best_i + 3));
            exp_lvl = user_prio[2*best_i +: 2];
          end
          @(negedge clk);
          chk("R2/R3/R4/R9 take", 32'(take_irq), 32'(best_i >= 0));
          chk("R6/R7/R12 vec", 32'(vec_addr), 32'(exp_vec));
          chk("R8/R12 lvl", 32'(new_lvl), 32'(exp_lvl));
        end
      end
    end

    // R5 non-maskables under full mask, precedence
    cur_lvl = 2'b11; user_req = 4'hF; user_prio = 8'hFF;
    nmi_req = 1; @(negedge clk);
    chk("R5 nmi take", 32'(take_irq), 1);
    chk("R5/R7 nmi vec", 32'(vec_addr), 32'(BASE + 24'd8));
    chk("R5 nmi lvl", 32'(new_lvl), 3);
    trap_req = 1; @(negedge clk);
    chk("R5/R7 trap vec", 32'(vec_addr), 32'(BASE + 24'd4));
    reset_req = 1; @(negedge clk);
    chk("R5/R7 reset vec", 32'(vec_addr), 32'(BASE));
    chk("R5 reset lvl", 32'(new_lvl), 3);
    reset_req = 0; trap_req = 0;
    cur_lvl = 2'b10; user_prio = 8'h00; @(negedge clk);
    chk("R5 nmi beats user", 32'(vec_addr), 32'(BASE + 24'd8));

    // R10 entry blanking with NMI held
    ent_ack = 1; @(negedge clk);
    chk("R10 blank first", 32'(take_irq), 0);
    ent_ack = 0; @(negedge clk);
    chk("R10 blank second", 32'(take_irq), 0);
    @(negedge clk);
    chk("R10 reoffer", 32'(take_irq), 1);
    nmi_req = 0; user_req = '0;

    // R11 return actions
    act_lvl = 0; ret_stb = 1; @(negedge clk);
    chk("R11 restore", 32'({ret_restore, ret_wait}), 32'h2);
    ret_stb = 0; @(negedge clk);
    chk("R11 restore pulse", 32'({ret_restore, ret_wait}), 0);
    act_lvl = 1; ret_stb = 1; @(negedge clk);
    chk("R11 wait", 32'({ret_restore, ret_wait}), 32'h1);
    ret_stb = 0; @(negedge clk);
    chk("R11 wait pulse", 32'({ret_restore, ret_wait}), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule